// File: doc/BRIEF.md
# I2C Byte Buffer Flag and Clock-Stretch Controller

This block sits between the byte shifter of an I2C port and whatever moves the data, either a host or a DMA engine. It owns the data register and three buffer flags: transmit empty (`tbe_o`), receive full (`rbne_o`) and byte-stalled (`btc_o`). When the buffer cannot keep pace with the bus, it asks the bit-level driver to hold SCL low through `scl_hold_o`. The shifter reports a finished received byte with `byte_done_i` and asks for the next byte to send with `byte_need_i`. The block answers a request with a one-cycle `tx_load_o` pulse, which carries the byte on `tx_byte_o`.

In slave mode the stall can be switched off with `stretch_off_i`. The buffer then never holds the clock. If the host falls behind, a received byte is dropped (overrun) or an all-ones byte goes out (underrun), and a sticky error flag is raised. When `dma_en_i` is set, the flags pace a DMA request/acknowledge pair, and each acknowledge performs the data-register access. For DMA master reception, a last-byte option does two things: it withholds the acknowledge bit on the final byte, and it pulses a STOP request once that byte has been taken.

Top module: `i2c_bufctl`

## Requirements
- R1: In receive mode with stretching active, a byte that completes while `rbne_o`=1 is parked, `btc_o` rises and `scl_hold_o` stays 1 until the data register is read. One cycle after that read, the parked byte is on `reg_rdata_o` and `rbne_o`=1 again.
- R2: In transmit mode with stretching active, `byte_need_i` while `tbe_o`=1 sets `btc_o` and holds `scl_hold_o` until a write. One cycle after the write clears `tbe_o`, `tx_load_o` pulses with the written byte and `tbe_o` returns to 1.
- R3: Stretching is disabled only when `slave_i`=1 and `stretch_off_i`=1. `stretch_off_i` has no effect in master mode, and with stretching disabled `scl_hold_o` stays 0.
- R4: Overrun: a byte that completes while the receive buffer is full and stretching is disabled is discarded. `reg_rdata_o` keeps the old byte and `ovr_o` is set.
- R5: Underrun: `byte_need_i` while `tbe_o`=1 and stretching is disabled produces a `tx_load_o` pulse with `tx_byte_o`=0xFF and sets `ovr_o`.
- R6: `ovr_o` is sticky until `ovr_clr_i`. A new error in the same cycle as a clear leaves it set.
- R7: `dma_req_o` = `dma_en_i` and (`rbne_o` in receive mode, `tbe_o` in transmit mode). `dma_ack_i` performs a read in receive mode, or a write of `dma_wdata_i` in transmit mode.
- R8: After the cycle in which `dma_ack_i` is 1, `dma_req_o` is 0 for at least one cycle.
- R9: The access that clears `rbne_o` or `tbe_o` also clears `btc_o`, and this is visible in the cycle after the access.
- R10: `ack_o` = `ack_en_i` in receive mode, and 0 in transmit mode. It is forced to 0 in master receive mode when `dma_en_i`, `dma_last_i` and `dma_final_i` are all 1.
- R11: In master receive mode with `dma_en_i` and `dma_last_i`, a `dma_ack_i` while `dma_final_i`=1 gives a single-cycle `stop_req_o` pulse in the next cycle.
- R12: After reset: `tbe_o`=1, `rbne_o`=0, `btc_o`=0, `ovr_o`=0, `scl_hold_o`=0, `tx_load_o`=0.
- R13: Unstalled flow: `byte_done_i` into an empty buffer loads `rx_byte_i` and sets `rbne_o` in the next cycle. `byte_need_i` with `tbe_o`=0 gives a `tx_load_o` pulse with the stored byte in the next cycle and sets `tbe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_i | input | 1 | 1 = slave role, 0 = master |
| stretch_off_i | input | 1 | Disable SCL holding (slave only) |
| rx_mode_i | input | 1 | 1 = receive, 0 = transmit |
| ack_en_i | input | 1 | Acknowledge received bytes |
| dma_en_i | input | 1 | Enable flag-paced DMA requests |
| dma_last_i | input | 1 | NACK the final DMA byte of a master reception |
| dma_final_i | input | 1 | DMA engine has one transfer left |
| byte_done_i | input | 1 | Shifter finished receiving a byte |
| rx_byte_i | input | DW | Received byte |
| byte_need_i | input | 1 | Shifter wants the next byte to send |
| tx_load_o | output | 1 | Byte handed to the shifter |
| tx_byte_o | output | DW | Byte to send |
| scl_hold_o | output | 1 | Hold SCL low |
| ack_o | output | 1 | Acknowledge bit for the current received byte |
| reg_rd_i | input | 1 | Host reads the data register |
| reg_wr_i | input | 1 | Host writes the data register |
| reg_wdata_i | input | DW | Host write data |
| reg_rdata_o | output | DW | Data register contents |
| ovr_clr_i | input | 1 | Clear the overrun/underrun flag |
| tbe_o | output | 1 | Transmit buffer empty |
| rbne_o | output | 1 | Receive buffer full |
| btc_o | output | 1 | Byte stalled on an empty/full buffer |
| ovr_o | output | 1 | Sticky overrun/underrun |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge; performs the access |
| dma_wdata_i | input | DW | DMA write data |
| stop_req_o | output | 1 | Request a STOP after the final DMA byte |

## Verification
The bench uses the default byte width of 8. At that width the 0xFF underrun pattern and all byte values are distinct and visible at the ports. The reference model keeps received bytes in a queue, so parked bytes, refills and discards are all checked against the order in which they arrived. Master and slave roles, both stretch settings, and host-driven and DMA-driven access are all exercised within one run.

// File: rtl/i2c_bufctl_pkg.sv
package i2c_bufctl_pkg;
  typedef enum logic {
    XFER_TX = 1'b0,
    XFER_RX = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic      stretch_en;
    logic      master;
    xfer_dir_e dir;
  } mode_t;
endpackage

// File: rtl/i2c_bufctl_rx.sv
module i2c_bufctl_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stretch_en_i,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_i,
  output logic [DW-1:0] dr_o,
  output logic          rbne_o,
  output logic          btc_o,
  output logic          ovr_set_o
);
  logic [DW-1:0] dr_q, park_q;
  logic rbne_q, btc_q, pend_q;
  logic rd_hit, space, park_ok;

  always_comb begin
    rd_hit  = rd_i & rbne_q;
    space   = (~rbne_q | rd_i) & ~pend_q & ~btc_q;
    park_ok = stretch_en_i & ~btc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q   <= '0;
      park_q <= '0;
      rbne_q <= 1'b0;
      btc_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // parked byte moves up one cycle after the read
      if (pend_q) begin
        dr_q   <= park_q;
        rbne_q <= 1'b1;
        pend_q <= 1'b0;
      end
      if (rd_hit) begin
        rbne_q <= 1'b0;
        btc_q  <= 1'b0;
        pend_q <= btc_q;
      end
      if (done_i) begin
        if (space) begin
          dr_q   <= data_i;
          rbne_q <= 1'b1;
        end else if (park_ok) begin
          park_q <= data_i;
          btc_q  <= 1'b1;
        end
      end
    end
  end

  assign dr_o      = dr_q;
  assign rbne_o    = rbne_q;
  assign btc_o     = btc_q;
  assign ovr_set_o = done_i & ~space & ~park_ok;

  assert_keep_old_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !space && !stretch_en_i && !pend_q) |=> $stable(dr_q));

  assert_btc_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !done_i) |=> !btc_q);
endmodule

// File: rtl/i2c_bufctl_tx.sv
module i2c_bufctl_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stretch_en_i,
  input  logic          need_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] dr_o,
  output logic          tbe_o,
  output logic          btc_o,
  output logic          load_o,
  output logic [DW-1:0] byte_o,
  output logic          unr_o
);
  localparam logic [DW-1:0] FILL = '1;

  logic [DW-1:0] dr_q, byte_q;
  logic tbe_q, btc_q, pend_q, load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q   <= '0;
      byte_q <= '0;
      tbe_q  <= 1'b1;
      btc_q  <= 1'b0;
      pend_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      // stalled request served once a write refilled the buffer
      if (pend_q && !tbe_q) begin
        byte_q <= dr_q;
        load_q <= 1'b1;
        tbe_q  <= 1'b1;
        pend_q <= 1'b0;
      end
      if (need_i) begin
        if (!tbe_q) begin
          byte_q <= dr_q;
          load_q <= 1'b1;
          tbe_q  <= 1'b1;
        end else if (stretch_en_i) begin
          btc_q  <= 1'b1;
          pend_q <= 1'b1;
        end else begin
          byte_q <= FILL;
          load_q <= 1'b1;
        end
      end
      if (wr_i) begin
        dr_q  <= wdata_i;
        tbe_q <= 1'b0;
        btc_q <= 1'b0;
      end
    end
  end

  assign dr_o   = dr_q;
  assign tbe_o  = tbe_q;
  assign btc_o  = btc_q;
  assign load_o = load_q;
  assign byte_o = byte_q;
  assign unr_o  = need_i & tbe_q & ~stretch_en_i;

  assert_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (need_i && tbe_q && !stretch_en_i && !wr_i) |=> (load_o && byte_o == FILL));

  assert_handover_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tbe_q) |=> (load_o && tbe_o));
endmodule

// File: rtl/i2c_bufctl_dma.sv
module i2c_bufctl_dma (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dir_rx_i,
  input  logic master_i,
  input  logic last_i,
  input  logic final_i,
  input  logic rbne_i,
  input  logic tbe_i,
  input  logic ack_i,
  output logic req_o,
  output logic nack_final_o,
  output logic stop_o
);
  logic gap_q, stop_q, last_rx;

  assign last_rx      = dir_rx_i & master_i & en_i & last_i & final_i;
  assign nack_final_o = last_rx;
  assign req_o        = en_i & (dir_rx_i ? rbne_i : tbe_i) & ~gap_q;
  assign stop_o       = stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      gap_q  <= ack_i;
      stop_q <= last_rx & ack_i;
    end
  end

  assert_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !req_o);

  assert_stop_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !(last_rx && ack_i)) |=> !stop_o);
endmodule

// File: rtl/i2c_bufctl.sv
module i2c_bufctl
  import i2c_bufctl_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slave_i,
  input  logic          stretch_off_i,
  input  logic          rx_mode_i,
  input  logic          ack_en_i,
  input  logic          dma_en_i,
  input  logic          dma_last_i,
  input  logic          dma_final_i,
  input  logic          byte_done_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          byte_need_i,
  output logic          tx_load_o,
  output logic [DW-1:0] tx_byte_o,
  output logic          scl_hold_o,
  output logic          ack_o,
  input  logic          reg_rd_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          ovr_clr_i,
  output logic          tbe_o,
  output logic          rbne_o,
  output logic          btc_o,
  output logic          ovr_o,
  output logic          dma_req_o,
  input  logic          dma_ack_i,
  input  logic [DW-1:0] dma_wdata_i,
  output logic          stop_req_o
);
  mode_t mode;
  logic is_rx, stretch_en;
  logic rx_rd, tx_wr, rx_done, tx_need;
  logic [DW-1:0] tx_wdata, rx_dr, tx_dr;
  logic rx_rbne, rx_btc, rx_ovr;
  logic tx_tbe, tx_btc, tx_unr;
  logic nack_final, ovr_q;

  always_comb begin
    mode.stretch_en = ~(slave_i & stretch_off_i);
    mode.master     = ~slave_i;
    mode.dir        = rx_mode_i ? XFER_RX : XFER_TX;
  end

  assign is_rx      = (mode.dir == XFER_RX);
  assign stretch_en = mode.stretch_en;
  assign rx_rd      = is_rx & (reg_rd_i | dma_ack_i);
  assign tx_wr      = ~is_rx & (reg_wr_i | dma_ack_i);
  assign tx_wdata   = reg_wr_i ? reg_wdata_i : dma_wdata_i;
  assign rx_done    = is_rx & byte_done_i;
  assign tx_need    = ~is_rx & byte_need_i;

  i2c_bufctl_rx #(.DW(DW)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stretch_en_i(stretch_en),
    .done_i      (rx_done),
    .data_i      (rx_byte_i),
    .rd_i        (rx_rd),
    .dr_o        (rx_dr),
    .rbne_o      (rx_rbne),
    .btc_o       (rx_btc),
    .ovr_set_o   (rx_ovr)
  );

  i2c_bufctl_tx #(.DW(DW)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stretch_en_i(stretch_en),
    .need_i      (tx_need),
    .wr_i        (tx_wr),
    .wdata_i     (tx_wdata),
    .dr_o        (tx_dr),
    .tbe_o       (tx_tbe),
    .btc_o       (tx_btc),
    .load_o      (tx_load_o),
    .byte_o      (tx_byte_o),
    .unr_o       (tx_unr)
  );

  i2c_bufctl_dma u_dma (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (dma_en_i),
    .dir_rx_i    (is_rx),
    .master_i    (mode.master),
    .last_i      (dma_last_i),
    .final_i     (dma_final_i),
    .rbne_i      (rx_rbne),
    .tbe_i       (tx_tbe),
    .ack_i       (dma_ack_i),
    .req_o       (dma_req_o),
    .nack_final_o(nack_final),
    .stop_o      (stop_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= (ovr_q & ~ovr_clr_i) | rx_ovr | tx_unr;
  end

  assign scl_hold_o  = stretch_en & (is_rx ? (rx_rbne & rx_btc) : (tx_tbe & tx_btc));
  assign ack_o       = is_rx & ack_en_i & ~nack_final;
  assign reg_rdata_o = is_rx ? rx_dr : tx_dr;
  assign tbe_o       = tx_tbe;
  assign rbne_o      = rx_rbne;
  assign btc_o       = is_rx ? rx_btc : tx_btc;
  assign ovr_o       = ovr_q;

  // R1 and R2: the hold persists until the data register is accessed
  assert_hold_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && !rx_rd && !tx_wr)
      |=> (scl_hold_o || !$stable(rx_mode_i) || !$stable(stretch_en)));

  assert_ovr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr_i) |=> ovr_q);
endmodule

// File: tb/tb_i2c_bufctl.sv
module tb_i2c_bufctl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic slave_i = 0, stretch_off_i = 0, rx_mode_i = 1, ack_en_i = 1;
  logic dma_en_i = 0, dma_last_i = 0, dma_final_i = 0;
  logic byte_done_i = 0, byte_need_i = 0;
  logic [7:0] rx_byte_i = '0;
  logic reg_rd_i = 0, reg_wr_i = 0, ovr_clr_i = 0, dma_ack_i = 0;
  logic [7:0] reg_wdata_i = '0, dma_wdata_i = '0;
  logic tx_load_o, scl_hold_o, ack_o, tbe_o, rbne_o, btc_o, ovr_o, dma_req_o, stop_req_o;
  logic [7:0] tx_byte_o, reg_rdata_o;

  always #4ns clk_i = ~clk_i;

  i2c_bufctl #(.DW(8)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference model
  logic [7:0] rxq[$];
  bit m_rbne, m_rbtc, m_refill, m_tbe, m_tbtc, m_tpend, m_load, m_ovr, m_gap, m_stop;
  logic [7:0] m_tdr, m_tbyte;

  always @(posedge clk_i or negedge rst_ni) begin
    bit stre, o_tbe, o_tpend, o_rbne, set, rx, rd, wr;
    logic [7:0] wd;
    if (!rst_ni) begin
      rxq.delete();
      m_rbne = 0; m_rbtc = 0; m_refill = 0; m_tbe = 1; m_tbtc = 0; m_tpend = 0;
      m_load = 0; m_ovr = 0; m_gap = 0; m_stop = 0; m_tdr = 0; m_tbyte = 0;
    end else begin
      stre = !(slave_i && stretch_off_i);
      rx = rx_mode_i;
      o_tbe = m_tbe; o_tpend = m_tpend; o_rbne = m_rbne;
      set = 0; m_load = 0;
      rd = rx && (reg_rd_i || dma_ack_i);
      wr = !rx && (reg_wr_i || dma_ack_i);
      wd = reg_wr_i ? reg_wdata_i : dma_wdata_i;
      if (m_refill) begin m_rbne = 1; m_refill = 0; end
      if (rd && o_rbne) begin
        void'(rxq.pop_front());
        m_rbne = 0; m_rbtc = 0;
        m_refill = (rxq.size() > 0);
      end
      if (rx && byte_done_i) begin
        if (rxq.size() == 0) begin rxq.push_back(rx_byte_i); m_rbne = 1; end
        else if (stre && rxq.size() == 1) begin rxq.push_back(rx_byte_i); m_rbtc = 1; end
        else set = 1;
      end
      if (o_tpend && !o_tbe) begin m_tbyte = m_tdr; m_load = 1; m_tbe = 1; m_tpend = 0; end
      if (!rx && byte_need_i) begin
        if (!o_tbe) begin m_tbyte = m_tdr; m_load = 1; m_tbe = 1; end
        else if (stre) begin m_tbtc = 1; m_tpend = 1; end
        else begin m_tbyte = 8'hFF; m_load = 1; set = 1; end
      end
      if (wr) begin m_tdr = wd; m_tbe = 0; m_tbtc = 0; end
      m_ovr = set || (m_ovr && !ovr_clr_i);
      m_stop = rx && !slave_i && dma_en_i && dma_last_i && dma_final_i && dma_ack_i;
      m_gap = dma_ack_i;
    end
  end

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    #1ns;
    if (rst_ni && !finished) begin
      bit stre;
      stre = !(slave_i && stretch_off_i);
      cmp("R13", "rbne", rbne_o, m_rbne);
      cmp("R13", "tbe", tbe_o, m_tbe);
      cmp("R9", "btc", btc_o, rx_mode_i ? m_rbtc : m_tbtc);
      cmp("R6", "ovr", ovr_o, m_ovr);
      cmp("R3", "scl_hold", scl_hold_o,
          stre && (rx_mode_i ? (m_rbne && m_rbtc) : (m_tbe && m_tbtc)));
      cmp("R7", "dma_req", dma_req_o, dma_en_i && (rx_mode_i ? m_rbne : m_tbe) && !m_gap);
      cmp("R10", "ack", ack_o,
          rx_mode_i && ack_en_i && !(!slave_i && dma_en_i && dma_last_i && dma_final_i));
      cmp("R11", "stop", stop_req_o, m_stop);
      cmp("R13", "tx_load", tx_load_o, m_load);
      if (m_load) cmp("R5", "tx_byte", tx_byte_o, m_tbyte);
      if (rx_mode_i && m_rbne) cmp("R1", "rdata", reg_rdata_o, rxq[0]);
    end
  end

  task automatic done_b(input logic [7:0] b);
    rx_byte_i = b; byte_done_i = 1; @(negedge clk_i); byte_done_i = 0;
  endtask
  task automatic need_b();
    byte_need_i = 1; @(negedge clk_i); byte_need_i = 0;
  endtask
  task automatic rd_b();
    reg_rd_i = 1; @(negedge clk_i); reg_rd_i = 0;
  endtask
  task automatic wr_b(input logic [7:0] b);
    reg_wdata_i = b; reg_wr_i = 1; @(negedge clk_i); reg_wr_i = 0;
  endtask
  task automatic clr_b();
    ovr_clr_i = 1; @(negedge clk_i); ovr_clr_i = 0;
  endtask
  task automatic dack_b(input logic [7:0] b);
    dma_wdata_i = b; dma_ack_i = 1; @(negedge clk_i); dma_ack_i = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL R13 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R12 reset state
    cmp("R12", "tbe", tbe_o, 1); cmp("R12", "rbne", rbne_o, 0);
    cmp("R12", "btc", btc_o, 0); cmp("R12", "ovr", ovr_o, 0);
    cmp("R12", "scl", scl_hold_o, 0); cmp("R12", "load", tx_load_o, 0);

    // R1 R13 master receive with stretching
    done_b(8'hA5);
    cmp("R13", "rbne", rbne_o, 1); cmp("R13", "rdata", reg_rdata_o, 8'hA5);
    done_b(8'h3C);
    cmp("R1", "btc", btc_o, 1); cmp("R1", "scl", scl_hold_o, 1);
    repeat (3) @(negedge clk_i);
    cmp("R1", "scl held", scl_hold_o, 1); cmp("R1", "rdata old", reg_rdata_o, 8'hA5);
    rd_b();
    cmp("R9", "btc", btc_o, 0); cmp("R9", "rbne", rbne_o, 0); cmp("R1", "scl", scl_hold_o, 0);
    @(negedge clk_i);
    cmp("R1", "rbne refill", rbne_o, 1); cmp("R1", "rdata park", reg_rdata_o, 8'h3C);
    rd_b();

    // R3 stretch_off ignored in master mode
    stretch_off_i = 1;
    done_b(8'h01); done_b(8'h02);
    cmp("R3", "scl master", scl_hold_o, 1);
    rd_b(); @(negedge clk_i); rd_b();

    // R4 overrun in slave mode without stretching
    slave_i = 1;
    done_b(8'h11); done_b(8'h22);
    cmp("R4", "ovr", ovr_o, 1); cmp("R4", "rdata kept", reg_rdata_o, 8'h11);
    cmp("R3", "scl off", scl_hold_o, 0);
    clr_b();
    cmp("R6", "ovr cleared", ovr_o, 0);
    rd_b();

    // R2 R13 master transmit with stretching
    rx_mode_i = 0; slave_i = 0; stretch_off_i = 0;
    @(negedge clk_i);
    wr_b(8'h5A);
    cmp("R13", "tbe", tbe_o, 0);
    need_b();
    cmp("R13", "load", tx_load_o, 1); cmp("R13", "byte", tx_byte_o, 8'h5A); cmp("R13", "tbe", tbe_o, 1);
    need_b();
    cmp("R2", "btc", btc_o, 1); cmp("R2", "scl", scl_hold_o, 1);
    repeat (2) @(negedge clk_i);
    wr_b(8'hC3);
    cmp("R9", "btc", btc_o, 0); cmp("R2", "scl", scl_hold_o, 0);
    @(negedge clk_i);
    cmp("R2", "load", tx_load_o, 1); cmp("R2", "byte", tx_byte_o, 8'hC3); cmp("R2", "tbe", tbe_o, 1);

    // R5 R6 underrun in slave mode without stretching
    slave_i = 1; stretch_off_i = 1;
    need_b();
    cmp("R5", "load", tx_load_o, 1); cmp("R5", "fill", tx_byte_o, 8'hFF); cmp("R5", "ovr", ovr_o, 1);
    ovr_clr_i = 1; byte_need_i = 1; @(negedge clk_i); ovr_clr_i = 0; byte_need_i = 0;
    cmp("R6", "set wins", ovr_o, 1);
    clr_b();

    // R7 R8 R10 R11 DMA master reception with last-byte NACK
    rx_mode_i = 1; slave_i = 0; stretch_off_i = 0;
    dma_en_i = 1; dma_last_i = 1; ack_en_i = 1;
    for (int i = 0; i < 3; i++) begin
      dma_final_i = (i == 2);
      #1ns;
      cmp("R10", "ack", ack_o, (i == 2) ? 0 : 1);
      @(negedge clk_i);
      done_b(8'h40 + 8'(i));
      cmp("R7", "req", dma_req_o, 1); cmp("R7", "rdata", reg_rdata_o, 8'h40 + 8'(i));
      dack_b(8'h00);
      cmp("R8", "req gap", dma_req_o, 0); cmp("R7", "rbne", rbne_o, 0);
      cmp("R11", "stop", stop_req_o, (i == 2) ? 1 : 0);
      @(negedge clk_i);
      cmp("R11", "stop pulse", stop_req_o, 0);
    end
    dma_final_i = 0; dma_last_i = 0; dma_en_i = 0;
    ack_en_i = 0;
    #1ns;
    cmp("R10", "single byte nack", ack_o, 0);
    ack_en_i = 1;

    // R7 R8 DMA transmit
    rx_mode_i = 0; dma_en_i = 1;
    @(negedge clk_i);
    cmp("R7", "tx req", dma_req_o, 1);
    dack_b(8'h77);
    cmp("R8", "tx gap", dma_req_o, 0); cmp("R7", "tbe", tbe_o, 0);
    need_b();
    cmp("R7", "dma byte", tx_byte_o, 8'h77);
    dma_en_i = 0;

    // mixed traffic, checked by the model every cycle
    rx_mode_i = 1;
    @(negedge clk_i);
    for (int i = 0; i < 40; i++) begin
      done_b(8'(i * 37 + 5));
      if (i % 3 != 0) begin rd_b(); @(negedge clk_i); end
      if (i % 5 == 0) begin rd_b(); @(negedge clk_i); rd_b(); end
    end
    rd_b(); @(negedge clk_i); rd_b();
    rx_mode_i = 0;
    @(negedge clk_i);
    for (int i = 0; i < 20; i++) begin
      if (i % 2 == 0) begin wr_b(8'(i * 11)); need_b(); end
      else begin need_b(); @(negedge clk_i); wr_b(8'(i * 11)); @(negedge clk_i); end
    end

    repeat (3) @(negedge clk_i);
    finished = 1;
    summary();
    $finish;
  end
endmodule